// File: doc/BRIEF.md
# 64-bit Timebase Counter with Dual Reference Compare

This block keeps a 64-bit free-running binary count that advances by one on every cycle in which the timer tick input is high and counting has been enabled. The count is visible on a 32-bit register bus as two separate halves. Each half can be read or written on its own. Software is expected to load the count itself, because only power-on reset clears it. After power-on reset the count is zero and stopped until software sets the run bit.

Two reference registers, each 64 bits wide and also split into halves, are compared against the count. When a tick moves the count onto a reference value, a status bit for that reference is set. Each status bit drives a shared interrupt line through its own enable bit, so both interrupts can be masked. The status bits are cleared by writing one to them.

The hard and soft reset inputs quiet the interrupt side only. They clear the status bits and the enable bits, and they leave the count, the references and the run bit alone.

Top module: `tbase_cmp`

## Requirements
- R1: While the run bit (control register bit 0, address 6) is 1, the count rises by exactly one on each clock edge where `tick` is high. While the run bit is 0, the count holds.
- R2: A tick that takes the lower half from all ones to zero also increments the upper half on the same edge. The 64-bit count wraps from all ones to zero.
- R3: Address 0 is the lower half of the count and address 1 is the upper half. Writing one half leaves the other half unchanged.
- R4: A write to either count half on the same edge as a tick stores the written value, and that tick adds nothing to either half.
- R5: Addresses 2/3 hold reference 0 (low/high) and addresses 4/5 hold reference 1. The status register (address 7) bit i is set on the edge where a tick makes the count equal to reference i. Both bits are set if both references match on the same tick.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a match and a clear fall on the same edge, the bit stays set.
- R7: `irq` is the OR, over both references, of status bit i AND its enable bit (control bit 1 for reference 0, bit 2 for reference 1). It is registered and follows the status one cycle later.
- R8: `por_rst` clears the count, both references, the control register (stopping the count), the status bits, `irq` and `bus_rdata`.
- R9: `hard_rst` and `soft_rst` leave the count, both references and the run bit unchanged. They clear the status bits, both enable bits and `irq`.
- R10: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented. Unused bits of the control and status registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| hard_rst | input | 1 | Synchronous active-high hard reset (interrupt side only) |
| soft_rst | input | 1 | Synchronous active-high soft reset (interrupt side only) |
| tick | input | 1 | Count enable pulse |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Maskable reference-match interrupt |

## Verification
The count is swept from sixteen lower-half start offsets just below the carry point, with twenty ticks each. This separates a correct carry from a missing carry, a doubled carry and a carry that arrives one tick late. Ticks are made to collide with count writes, status clears and half writes, which shows whether write priority, set-over-clear and half independence hold. The references are placed at distinct values, at the same value, and under one enable at a time. This tells apart a wrong status bit, a missed simultaneous match and a broken mask. Power-on, hard and soft resets are each applied to a loaded, running block, which shows which state each reset is allowed to touch.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // Register map helpers: count halves first, then reference pairs,
  // then control, then status.
  function automatic int ref_addr(input int idx, input int half);
    return 2 + 2 * idx + half;
  endfunction

  function automatic int ctrl_addr(input int nref);
    return 2 + 2 * nref;
  endfunction

  function automatic int stat_addr(input int nref);
    return 3 + 2 * nref;
  endfunction
endpackage

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          sys_rst,
  input  logic          run,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic [HW-1:0] cnt_lo,
  output logic [HW-1:0] cnt_hi,
  output logic          step,
  output logic [2*HW-1:0] cnt_plus1
);
  localparam logic [2*HW-1:0] ONE = {{(2*HW-1){1'b0}}, 1'b1};

  // Any write to the count swallows the tick of that cycle.
  assign step      = run & tick & ~wr_lo & ~wr_hi;
  assign cnt_plus1 = {cnt_hi, cnt_lo} + ONE;

  always_ff @(posedge clk) begin
    if (por_rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      if (wr_lo)     cnt_lo <= wdata;
      else if (step) cnt_lo <= cnt_plus1[HW-1:0];
      if (wr_hi)     cnt_hi <= wdata;
      else if (step) cnt_hi <= cnt_plus1[2*HW-1:HW];
    end
  end

  assert_por_clear_R8: assert property (@(posedge clk)
    por_rst |=> (cnt_lo == '0 && cnt_hi == '0));

  assert_carry_R2: assert property (@(posedge clk) disable iff (por_rst)
    (step && cnt_lo == '1) |=> (cnt_lo == '0 && cnt_hi == $past(cnt_hi) + 1'b1));

  assert_half_indep_R3: assert property (@(posedge clk) disable iff (por_rst)
    (wr_lo && !wr_hi) |=> $stable(cnt_hi));

  assert_write_wins_R4: assert property (@(posedge clk) disable iff (por_rst)
    (wr_lo && tick) |=> (cnt_lo == $past(wdata)));

  assert_ignore_sys_R9: assert property (@(posedge clk) disable iff (por_rst)
    (sys_rst && !tick && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: rtl/tbase_ref.sv
module tbase_ref #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            por_rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wdata,
  input  logic            step,
  input  logic [2*HW-1:0] cnt_plus1,
  output logic [HW-1:0]   ref_lo,
  output logic [HW-1:0]   ref_hi,
  output logic            hit
);
  always_ff @(posedge clk) begin
    if (por_rst) begin
      ref_lo <= '0;
      ref_hi <= '0;
    end else begin
      if (wr_lo) ref_lo <= wdata;
      if (wr_hi) ref_hi <= wdata;
    end
  end

  // A match is taken from the value the count is about to reach.
  assign hit = step && (cnt_plus1 == {ref_hi, ref_lo});

  assert_ref_hold_R5: assert property (@(posedge clk) disable iff (por_rst)
    (!wr_lo && !wr_hi) |=> ($stable(ref_lo) && $stable(ref_hi)));
endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl #(
  parameter int NREF = 2
) (
  input  logic            clk,
  input  logic            por_rst,
  input  logic            sys_rst,
  input  logic            wr_ctrl,
  input  logic            wr_stat,
  input  logic [NREF:0]   wdata,
  input  logic [NREF-1:0] hit,
  output logic            run,
  output logic [NREF-1:0] en,
  output logic [NREF-1:0] stat,
  output logic            irq
);
  logic [NREF-1:0] clr;
  assign clr = wr_stat ? wdata[NREF-1:0] : '0;

  always_ff @(posedge clk) begin
    if (por_rst) begin
      run  <= 1'b0;
      en   <= '0;
      stat <= '0;
      irq  <= 1'b0;
    end else if (sys_rst) begin
      en   <= '0;
      stat <= '0;
      irq  <= 1'b0;
      if (wr_ctrl) run <= wdata[0];
    end else begin
      if (wr_ctrl) begin
        run <= wdata[0];
        en  <= wdata[NREF:1];
      end
      stat <= (stat & ~clr) | hit;
      irq  <= |(stat & en);
    end
  end

  assert_sys_clear_R9: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> (stat == '0 && en == '0 && !irq));

  assert_run_kept_R9: assert property (@(posedge clk) disable iff (por_rst)
    (sys_rst && !wr_ctrl) |=> (run == $past(run)));

  assert_hit_sets_R5: assert property (@(posedge clk) disable iff (por_rst)
    (!sys_rst && hit != '0) |=> ((stat & $past(hit)) == $past(hit)));

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (por_rst)
    (!sys_rst && wr_stat && hit != '0) |=> ((stat & $past(hit)) != '0));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (por_rst)
    ((stat & en) == '0) |=> !irq);
endmodule

// File: rtl/tbase_cmp.sv
module tbase_cmp #(
  parameter int HW   = 32,
  parameter int NREF = 2,
  localparam int AW  = $clog2(4 + 2 * NREF)
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          hard_rst,
  input  logic          soft_rst,
  input  logic          tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [HW-1:0] bus_wdata,
  output logic [HW-1:0] bus_rdata,
  output logic          irq
);
  import tbase_pkg::*;

  localparam int A_CTRL = ctrl_addr(NREF);
  localparam int A_STAT = stat_addr(NREF);

  logic            sys_rst;
  logic            run;
  logic [NREF-1:0] en;
  logic [NREF-1:0] stat;
  logic [NREF-1:0] hit;
  logic [HW-1:0]   cnt_lo, cnt_hi;
  logic            step;
  logic [2*HW-1:0] cnt_plus1;
  logic [HW-1:0]   ref_lo [NREF];
  logic [HW-1:0]   ref_hi [NREF];
  logic [HW-1:0]   rd_word;
  logic            wr_ctrl, wr_stat;

  assign sys_rst = hard_rst | soft_rst;
  assign wr_ctrl = bus_wr && (int'(bus_addr) == A_CTRL);
  assign wr_stat = bus_wr && (int'(bus_addr) == A_STAT);

  tbase_counter #(.HW(HW)) u_cnt (
    .clk       (clk),
    .por_rst   (por_rst),
    .sys_rst   (sys_rst),
    .run       (run),
    .tick      (tick),
    .wr_lo     (bus_wr && bus_addr == '0),
    .wr_hi     (bus_wr && int'(bus_addr) == 1),
    .wdata     (bus_wdata),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .step      (step),
    .cnt_plus1 (cnt_plus1)
  );

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    tbase_ref #(.HW(HW)) u_ref (
      .clk       (clk),
      .por_rst   (por_rst),
      .wr_lo     (bus_wr && int'(bus_addr) == ref_addr(i, 0)),
      .wr_hi     (bus_wr && int'(bus_addr) == ref_addr(i, 1)),
      .wdata     (bus_wdata),
      .step      (step),
      .cnt_plus1 (cnt_plus1),
      .ref_lo    (ref_lo[i]),
      .ref_hi    (ref_hi[i]),
      .hit       (hit[i])
    );
  end

  tbase_ctrl #(.NREF(NREF)) u_ctrl (
    .clk     (clk),
    .por_rst (por_rst),
    .sys_rst (sys_rst),
    .wr_ctrl (wr_ctrl),
    .wr_stat (wr_stat),
    .wdata   (bus_wdata[NREF:0]),
    .hit     (hit),
    .run     (run),
    .en      (en),
    .stat    (stat),
    .irq     (irq)
  );

  always_comb begin
    rd_word = '0;
    if (bus_addr == '0)                rd_word = cnt_lo;
    else if (int'(bus_addr) == 1)      rd_word = cnt_hi;
    else if (int'(bus_addr) == A_CTRL) rd_word[NREF:0] = {en, run};
    else if (int'(bus_addr) == A_STAT) rd_word[NREF-1:0] = stat;
    for (int i = 0; i < NREF; i++) begin
      if (int'(bus_addr) == ref_addr(i, 0)) rd_word = ref_lo[i];
      if (int'(bus_addr) == ref_addr(i, 1)) rd_word = ref_hi[i];
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) bus_rdata <= '0;
    else         bus_rdata <= rd_word;
  end

  assert_rdata_por_R8: assert property (@(posedge clk)
    por_rst |=> (bus_rdata == '0 && !irq));

  assert_stat_read_R10: assert property (@(posedge clk) disable iff (por_rst)
    (int'(bus_addr) == A_STAT) |=> (bus_rdata[HW-1:NREF] == '0));
endmodule

// File: tb/sim_tbase_cmp.sv
module sim_tbase_cmp;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, hard_rst = 1'b0, soft_rst = 1'b0;
  logic        tick = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] model;
  logic [31:0] d;

  always #4 clk = ~clk;

  tbase_cmp u0 (
    .clk(clk), .por_rst(por_rst), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 3'(a);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pulse_tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_count(input string req, input logic [63:0] exp);
    logic [31:0] lo, hi;
    rd(0, lo); rd(1, hi);
    chk({hi, lo} == exp, req, {hi, lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst = 1'b0;

    // R8 reset state of every register
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d == 0, "R8 reset register", 64'(d), 0);
    end
    chk(irq == 0, "R8 irq after reset", 64'(irq), 0);

    // R1 stopped after reset
    pulse_tick(3);
    chk_count("R1 no count while stopped", 0);

    // R10 unused control bits read zero
    wr(6, 32'hFFFF_FFF9);
    rd(6, d);
    chk(d == 32'h1, "R10 control readback", 64'(d), 1);

    // R1/R2 carry across halves
    wr(0, 32'hFFFF_FFFE); wr(1, 32'h5);
    pulse_tick(3);
    chk_count("R2 carry into upper half", 64'h6_0000_0001);

    // R3 half independence
    wr(0, 32'hA5);
    chk_count("R3 lower write keeps upper", 64'h6_0000_00A5);
    wr(1, 32'h1234);
    chk_count("R3 upper write keeps lower", 64'h1234_0000_00A5);

    // R4 write wins over tick
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 32'h77; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
    chk_count("R4 write suppresses tick", 64'h1234_0000_0077);

    // R1 run bit off holds
    wr(6, 0);
    pulse_tick(2);
    chk_count("R1 hold with run clear", 64'h1234_0000_0077);
    wr(6, 1);

    // R2 wrap of the full count
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    pulse_tick(1);
    chk_count("R2 wrap to zero", 0);
    wr(7, 32'h3);

    // R1/R2 sweep across the carry point
    for (int s = 0; s < 16; s++) begin
      model = {32'(s), 32'hFFFF_FFF0 + 32'(s)};
      wr(0, model[31:0]); wr(1, model[63:32]);
      pulse_tick(20);
      model = model + 64'd20;
      chk_count("R2 sweep", model);
    end

    // R5/R7 distinct references
    wr(7, 32'h3);
    wr(0, 32'h100); wr(1, 32'h9);
    wr(2, 32'h102); wr(3, 32'h9);
    wr(4, 32'h104); wr(5, 32'h9);
    wr(6, 32'h7);
    pulse_tick(1);
    rd(7, d);
    chk(d == 0, "R5 no status before match", 64'(d), 0);
    chk(irq == 0, "R7 irq low before match", 64'(irq), 0);
    pulse_tick(1);
    rd(7, d);
    chk(d == 1, "R5 reference 0 match", 64'(d), 1);
    chk(irq == 1, "R7 irq from reference 0", 64'(irq), 1);
    pulse_tick(2);
    rd(7, d);
    chk(d == 3, "R5 reference 1 match", 64'(d), 3);

    // R6 write-1-to-clear per bit
    wr(7, 32'h1);
    rd(7, d);
    chk(d == 2, "R6 clear bit 0 only", 64'(d), 2);
    wr(7, 32'h2);
    rd(7, d);
    chk(d == 0, "R6 clear bit 1", 64'(d), 0);
    chk(irq == 0, "R7 irq drops after clear", 64'(irq), 0);

    // R5 simultaneous match
    wr(0, 32'h200); wr(1, 32'h0);
    wr(2, 32'h201); wr(3, 32'h0);
    wr(4, 32'h201); wr(5, 32'h0);
    pulse_tick(1);
    rd(7, d);
    chk(d == 3, "R5 simultaneous match", 64'(d), 3);
    wr(7, 32'h3);

    // R7 enable masking
    wr(6, 32'h5);
    wr(0, 32'h300); wr(2, 32'h301); wr(4, 32'h350);
    pulse_tick(1);
    rd(7, d);
    chk(d == 1, "R7 status set while masked", 64'(d), 1);
    chk(irq == 0, "R7 masked reference 0", 64'(irq), 0);
    wr(7, 32'h3);

    // R6 set beats clear on the same edge
    wr(0, 32'h400); wr(2, 32'h401);
    @(negedge clk); bus_addr = 3'd7; bus_wdata = 32'h1; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
    rd(7, d);
    chk(d[0] == 1'b1, "R6 set wins over clear", 64'(d), 1);

    // R9 hard reset
    wr(6, 32'h7);
    @(negedge clk); hard_rst = 1'b1;
    @(negedge clk); hard_rst = 1'b0;
    chk_count("R9 count kept across hard reset", 64'h0000_0000_0000_0401);
    rd(2, d);
    chk(d == 32'h401, "R9 reference kept", 64'(d), 64'h401);
    rd(6, d);
    chk(d == 1, "R9 run kept, enables cleared", 64'(d), 1);
    rd(7, d);
    chk(d == 0, "R9 status cleared", 64'(d), 0);
    chk(irq == 0, "R9 irq cleared", 64'(irq), 0);

    // R9 soft reset
    wr(6, 32'h7);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(6, d);
    chk(d == 1, "R9 soft reset control", 64'(d), 1);
    pulse_tick(1);
    chk_count("R9 still counting after soft reset", 64'h402);

    // R8 power-on reset of a loaded block
    @(negedge clk); por_rst = 1'b1;
    @(negedge clk); por_rst = 1'b0;
    chk_count("R8 count cleared", 0);
    rd(4, d);
    chk(d == 0, "R8 reference cleared", 64'(d), 0);
    pulse_tick(2);
    chk_count("R8 stopped after power-on", 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule